// File: doc/BRIEF.md
# Oversampled Serial Receive Deframer

This block turns an asynchronous serial line into parallel receive words. It counts a free-running tick that runs at sixteen times the bit rate. A falling edge on the synchronized line starts a character. The start bit is confirmed low half a bit later. After that, every data bit, the optional appended bit and the stop bit are sampled one bit period apart. Data arrives least significant bit first. The character length is either seven or eight data bits. An optional extra bit can follow the data; it is captured as it arrives and is not computed.

Each completed character produces a single-cycle write strobe with a 9-bit word, meant for a downstream receive queue. The strobe fires whether the frame was good or bad. A stop bit sampled low raises a sticky framing-error flag. Any failure sends the receiver back to hunting for a new falling edge. A receive-available flag tells the consumer that a word has been delivered.

Top module: `serial_rx_deframer`

## Requirements
- R1: A start is accepted only if the synchronized line is still low at the eighth tick after a falling edge is seen. If it is high there, the receiver goes back to hunting and no word is produced.
- R2: With `cfg_seven_i`=0, eight data bits are received, first bit on the line into `word_o[0]`, and delivered in `word_o[7:0]`.
- R3: With `cfg_seven_i`=1, seven data bits are received into `word_o[6:0]` and `word_o[7]` is delivered as 0.
- R4: With `cfg_extra_i`=1, one more bit is sampled after the data bits and delivered in `word_o[8]`. With `cfg_extra_i`=0 no such bit is sampled and `word_o[8]` is 0.
- R5: `word_we_o` is high for exactly one clock per accepted character. If a register first captures the falling line at clock edge k and the tick is high on every cycle, that clock is the one after edge k+26+16*N, where N counts the data bits plus the extra bit. Only the first stop bit is sampled.
- R6: A stop bit sampled as 0 sets `frame_err_o` in the same clock as the strobe, and the word is still delivered.
- R7: `frame_err_o` stays set until a character with a high stop bit is delivered or `err_clr_i` is pulsed. `avail_clr_i` does not clear it. If an error and a clear arrive in the same clock, the error wins.
- R8: `rx_avail_o` is set in the clock of every strobe and cleared by `avail_clr_i`. A strobe wins over a clear in the same clock.
- R9: While a character is in progress, bit timing advances only on clocks where `tick16_i` is high. Holding the tick low for P clocks delays the strobe by P clocks.
- R10: `cfg_seven_i` and `cfg_extra_i` are captured when the start bit is confirmed. Changing them in the middle of a character does not alter that character.
- R11: After reset, `word_we_o`, `frame_err_o` and `rx_avail_o` are 0 and `word_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick16_i | input | 1 | Enable at sixteen times the bit rate |
| cfg_seven_i | input | 1 | 1 selects seven data bits |
| cfg_extra_i | input | 1 | 1 adds one received bit after the data |
| err_clr_i | input | 1 | Clears the framing-error flag |
| avail_clr_i | input | 1 | Consumer acknowledge, clears the available flag |
| word_we_o | output | 1 | One-clock strobe for a delivered word |
| word_o | output | 9 | {extra bit, data[7:0]} |
| frame_err_o | output | 1 | Sticky framing-error flag |
| rx_avail_o | output | 1 | Word delivered and not yet acknowledged |

## Verification
The strobe follows the first register capture of the falling edge by 26 + 16 times the number of sampled bits clocks. Every clock on which the tick was held low adds one clock. The bench works out this due clock when it starts driving each frame. It then compares the strobe, the word and both flags on every clock, one time unit after the rising edge, against a queue of expected words. The flag updates from `err_clr_i` and `avail_clr_i` are expected on the first rising edge that samples them, so they are visible at the next comparison point.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WORD_W = DATA_W + 1;

  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_DATA, ST_EXTRA, ST_STOP
  } srx_state_e;

  // index of the final data bit for the chosen character length
  function automatic logic [2:0] last_data_idx(input logic seven);
    return seven ? 3'd6 : 3'd7;
  endfunction

  // assemble the delivered word: extra bit on top, MSB masked for short chars
  function automatic logic [WORD_W-1:0] pack_word(input logic [DATA_W-1:0] data,
                                                  input logic extra,
                                                  input logic seven);
    logic [DATA_W-1:0] d;
    d = data;
    if (seven) d[DATA_W-1] = 1'b0;
    return {extra, d};
  endfunction
endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_s_o = sync_q;
  assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_s_i,
  input  logic              fall_i,
  input  logic              tick_i,
  input  logic              cfg_seven_i,
  input  logic              cfg_extra_i,
  output logic              stop_evt_o,
  output logic              stop_bit_o,
  output logic              word_we_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OVS / 2 - 1);

  srx_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              extra_q, seven_q, extra_en_q, we_q;
  logic [WORD_W-1:0] word_q;

  logic mid_hit, bit_end;
  assign mid_hit = tick_i && (cnt_q == MID_CNT);
  assign bit_end = tick_i && (cnt_q == END_CNT);

  assign stop_evt_o = (state_q == ST_STOP) && bit_end;
  assign stop_bit_o = rx_s_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      cnt_q      <= '0;
      idx_q      <= '0;
      shreg_q    <= '0;
      extra_q    <= 1'b0;
      seven_q    <= 1'b0;
      extra_en_q <= 1'b0;
      we_q       <= 1'b0;
      word_q     <= '0;
    end else begin
      we_q <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (fall_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
        end
        ST_START: begin
          if (mid_hit) begin
            cnt_q <= '0;
            if (!rx_s_i) begin
              state_q    <= ST_DATA;
              idx_q      <= '0;
              shreg_q    <= '0;
              extra_q    <= 1'b0;
              seven_q    <= cfg_seven_i;
              extra_en_q <= cfg_extra_i;
            end else begin
              state_q <= ST_HUNT;
            end
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q          <= '0;
            shreg_q[idx_q] <= rx_s_i;
            if (idx_q == last_data_idx(seven_q))
              state_q <= extra_en_q ? ST_EXTRA : ST_STOP;
            else
              idx_q <= idx_q + 1'b1;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_EXTRA: begin
          if (bit_end) begin
            cnt_q   <= '0;
            extra_q <= rx_s_i;
            state_q <= ST_STOP;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            cnt_q   <= '0;
            state_q <= ST_HUNT;
            we_q    <= 1'b1;
            word_q  <= pack_word(shreg_q, extra_q, seven_q);
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign word_we_o = we_q;
  assign word_o    = word_q;

  AST_FALSE_START_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && mid_hit && rx_s_i) |=> (state_q == ST_HUNT)); // R1
  AST_SHORT_CHAR_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && seven_q) |-> !word_q[DATA_W-1]); // R3
  AST_NO_EXTRA_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && !extra_en_q) |-> !word_q[WORD_W-1]); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q); // R5
  AST_TICK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_HUNT && !tick_i) |=> ($stable(cnt_q) && $stable(state_q))); // R9
endmodule

// File: rtl/srx_flags.sv
module srx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_evt_i,
  input  logic stop_bit_i,
  input  logic err_clr_i,
  input  logic avail_clr_i,
  output logic frame_err_o,
  output logic rx_avail_o
);
  logic fe_q, av_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fe_q <= 1'b0;
      av_q <= 1'b0;
    end else begin
      if (stop_evt_i)     fe_q <= ~stop_bit_i;
      else if (err_clr_i) fe_q <= 1'b0;
      if (stop_evt_i)       av_q <= 1'b1;
      else if (avail_clr_i) av_q <= 1'b0;
    end
  end

  assign frame_err_o = fe_q;
  assign rx_avail_o  = av_q;

  AST_BAD_STOP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt_i && !stop_bit_i) |=> fe_q); // R6
  AST_GOOD_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt_i && stop_bit_i) |=> !fe_q); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_evt_i && !err_clr_i) |=> $stable(fe_q)); // R7
  AST_AVAIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_clr_i && !stop_evt_i) |=> !av_q); // R8
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
  import srx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick16_i,
  input  logic              cfg_seven_i,
  input  logic              cfg_extra_i,
  input  logic              err_clr_i,
  input  logic              avail_clr_i,
  output logic              word_we_o,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_err_o,
  output logic              rx_avail_o
);
  logic rx_s, rx_fall, stop_evt, stop_bit;

  srx_line_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (rx_fall)
  );

  srx_frame_fsm #(.OVS(OVS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_s_i      (rx_s),
    .fall_i      (rx_fall),
    .tick_i      (tick16_i),
    .cfg_seven_i (cfg_seven_i),
    .cfg_extra_i (cfg_extra_i),
    .stop_evt_o  (stop_evt),
    .stop_bit_o  (stop_bit),
    .word_we_o   (word_we_o),
    .word_o      (word_o)
  );

  srx_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_evt_i  (stop_evt),
    .stop_bit_i  (stop_bit),
    .err_clr_i   (err_clr_i),
    .avail_clr_i (avail_clr_i),
    .frame_err_o (frame_err_o),
    .rx_avail_o  (rx_avail_o)
  );

  AST_STROBE_MARKS_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_we_o |-> rx_avail_o); // R8
endmodule

// File: tb/serial_rx_deframer_tb_top.sv
`timescale 1ns/1ps
module serial_rx_deframer_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, rx = 1'b1, tick = 1'b1, sev = 1'b0, xen = 1'b0;
  logic err_clr = 1'b0, av_clr = 1'b0;
  logic word_we, fe, av;
  logic [8:0] word;

  serial_rx_deframer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick16_i(tick),
    .cfg_seven_i(sev), .cfg_extra_i(xen), .err_clr_i(err_clr),
    .avail_clr_i(av_clr), .word_we_o(word_we), .word_o(word),
    .frame_err_o(fe), .rx_avail_o(av)
  );

  typedef struct { int due; logic [8:0] w; bit bad; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0, seen = 0, expd = 0;
  string cur_req = "R11";
  bit m_fe = 0, m_av = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison
  initial begin
    bit we_exp;
    exp_t e;
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      if (!rst_n) begin
        q.delete(); m_fe = 0; m_av = 0;
      end else begin
        we_exp = 0;
        if (q.size() > 0 && q[0].due == cyc) begin
          we_exp = 1;
          e = q.pop_front();
        end
        chk(word_we == we_exp, "R5", "strobe", word_we, we_exp);
        if (we_exp && word_we) chk(word == e.w, cur_req, "word", word, e.w);
        if (we_exp) m_fe = e.bad;
        else if (err_clr) m_fe = 0;
        if (we_exp) m_av = 1;
        else if (av_clr) m_av = 0;
        chk(fe == m_fe, "R7", "frame_err", fe, m_fe);
        chk(av == m_av, "R8", "rx_avail", av, m_av);
        if (word_we) seen++;
      end
    end
  end

  task automatic send(input logic [7:0] d, input bit xb, input bit s7, input bit xe,
                      input bit stop_ok, input int pj, input int pl, input bit flip);
    int nb, last;
    logic b;
    logic [8:0] w;
    exp_t e;
    @(negedge clk);
    sev = s7; xen = xe;
    nb = s7 ? 7 : 8;
    last = nb + (xe ? 1 : 0) + 1;
    w = {xe ? xb : 1'b0, s7 ? {1'b0, d[6:0]} : d};
    e.due = cyc + 1 + 26 + 16 * (nb + (xe ? 1 : 0)) + pl;
    e.w = w; e.bad = !stop_ok;
    q.push_back(e);
    expd++;
    for (int j = 0; j <= last; j++) begin
      if (j == 0) b = 1'b0;
      else if (j <= nb) b = d[j-1];
      else if (xe && j == nb + 1) b = xb;
      else b = stop_ok;
      rx = b;
      if (flip && j == 3) begin sev = !s7; xen = !xe; end
      if (j == pj && pl > 0) begin
        tick = 1'b0;
        repeat (pl) @(negedge clk);
        tick = 1'b1;
      end
      repeat (16) @(negedge clk);
    end
    rx = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_err_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  task automatic pulse_av_clr();
    @(negedge clk) av_clr = 1'b1;
    @(negedge clk) av_clr = 1'b0;
  endtask

  task automatic count_check(string req);
    chk(seen == expd, req, "word count", seen, expd);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(word_we == 0, "R11", "reset strobe", word_we, 0);
    chk(fe == 0, "R11", "reset frame_err", fe, 0);
    chk(av == 0, "R11", "reset rx_avail", av, 0);
    chk(word == 0, "R11", "reset word", word, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cur_req = "R2";
    send(8'hA5, 0, 0, 0, 1, 0, 0, 0);
    send(8'h3C, 0, 0, 0, 1, 0, 0, 0);
    count_check("R2");

    cur_req = "R4";
    send(8'h5A, 1, 0, 1, 1, 0, 0, 0);
    send(8'hC3, 0, 0, 1, 1, 0, 0, 0);
    send(8'h81, 1, 0, 0, 1, 0, 0, 0);
    count_check("R4");

    cur_req = "R3";
    send(8'hFF, 0, 1, 0, 1, 0, 0, 0);
    send(8'h2B, 1, 1, 1, 1, 0, 0, 0);
    count_check("R3");

    cur_req = "R6";
    send(8'h66, 0, 0, 0, 0, 0, 0, 0);
    chk(fe == 1, "R6", "error after bad stop", fe, 1);
    count_check("R6");

    cur_req = "R7";
    pulse_av_clr();
    @(negedge clk);
    chk(fe == 1, "R7", "error kept after acknowledge", fe, 1);
    pulse_err_clr();
    @(negedge clk);
    chk(fe == 0, "R7", "error after clear", fe, 0);
    send(8'h11, 0, 1, 0, 0, 0, 0, 0);
    send(8'h22, 0, 0, 0, 1, 0, 0, 0);
    chk(fe == 0, "R7", "error after good frame", fe, 0);

    cur_req = "R8";
    chk(av == 1, "R8", "available set", av, 1);
    pulse_av_clr();
    @(negedge clk);
    chk(av == 0, "R8", "available cleared", av, 0);

    cur_req = "R1";
    @(negedge clk) rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (40) @(negedge clk);
    count_check("R1");
    send(8'h96, 0, 0, 0, 1, 0, 0, 0);
    count_check("R1");

    cur_req = "R9";
    send(8'h4E, 1, 0, 1, 1, 3, 11, 0);
    count_check("R9");

    cur_req = "R10";
    send(8'hD7, 1, 0, 1, 1, 0, 0, 1);
    send(8'hE9, 0, 1, 0, 1, 0, 0, 1);
    count_check("R10");

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R5", "pending words", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule